// File: doc/BRIEF.md
# Command-Block DMA Engine

This engine copies a run of data words from a device into memory without the host moving any data itself. The host prepares a three-word command block in memory and writes the block's address into the engine in one cycle, after which it can go on with other work. The engine reads the block over its memory master port, keeps the device pointer, the memory pointer and the byte count, and then moves one word each time the device asks for it.

Each word is paced by a two-wire handshake. The device raises a request when it has a word. The engine takes the memory bus, drives the memory pointer as the write address and raises acknowledge. The device then places its word on the data input and lowers its request. When the count runs out the engine raises a completion flag and a one-cycle interrupt pulse. It then stays quiet until the host gives it a new block address.

Top module: `dma_cb_engine`

## Requirements
- R1: After reset, busy, done, irq, dack and mem_req are all low.
- R2: A host write (host_we high) while the engine is idle loads host_wdata as the block address, sets busy and clears done in the next cycle. A host write while busy has no effect and causes no bus cycle.
- R3: Before any data write, the engine makes exactly three memory reads, at block address +0, +4 and +8. These words are taken in that order as the device pointer, the memory pointer and the byte count.
- R4: dack rises only after dreq has been seen high. While the write for that word is requested, mem_we is high, mem_addr is the current memory pointer and mem_wdata equals dev_data. No read is made while dack is high.
- R5: dack stays high for as long as dreq stays high. It drops in the cycle after the engine sees dreq low with the write granted. A further word is taken only on a new rising dreq.
- R6: Each granted data write advances the memory pointer by 4 and lowers the remaining byte count by 4, with the count floored at zero. A count that is not a multiple of 4 therefore moves the count divided by 4, rounded up, in words.
- R7: The release of the last word's handshake sets done, pulses irq high for exactly one cycle and clears busy. After that, dreq gets no dack and starts no bus cycle.
- R8: A byte count of zero ends the job right after the third read, with done and an irq pulse and no data write.
- R9: Once mem_req is high without mem_gnt, mem_req, mem_we and mem_addr hold their values until the grant.
- R10: While dack is high, dev_port shows the device pointer read from the command block.
- R11: A host write that arrives in the same cycle the final handshake completes is ignored. The engine ends idle with done set and makes no new reads.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| host_we | input | 1 | Host write strobe for the command-block address |
| host_wdata | input | ADDR_W | Command-block address written by the host |
| mem_req | output | 1 | Memory bus request |
| mem_we | output | 1 | Memory direction: 1 write, 0 read |
| mem_addr | output | ADDR_W | Memory byte address |
| mem_wdata | output | DATA_W | Memory write data |
| mem_rdata | input | DATA_W | Memory read data, valid with mem_gnt |
| mem_gnt | input | 1 | Memory grant; the access completes in this cycle |
| dreq | input | 1 | Device request: a word is ready |
| dack | output | 1 | Acknowledge to the device |
| dev_data | input | DATA_W | Device word, driven while dack is high |
| dev_port | output | ADDR_W | Device pointer taken from the command block |
| busy | output | 1 | A job is in progress |
| done | output | 1 | The last job has completed |
| irq | output | 1 | One-cycle completion interrupt |

## Verification
The host's start write and the completion of the final handshake can land on the same clock edge. The bench provokes this by pulsing host_we in the very cycle the device lowers its last request. The design should pass if, one cycle later, the engine is idle with done and irq high and the scoreboard sees no extra command-block reads. A second scenario tests a start written mid-transfer while grants are stalled. That case is judged the same way, by the absence of any unexpected bus cycle.

// File: rtl/dma_cb_pkg.sv
package dma_cb_pkg;

    localparam int BLK_WORDS = 3;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_FETCH,
        ST_WAIT,
        ST_WRITE,
        ST_HOLD
    } dma_state_e;

    // Field order inside the command block; the fetch sequence follows it.
    typedef enum logic [1:0] {
        FLD_SRC = 2'd0,
        FLD_DST = 2'd1,
        FLD_CNT = 2'd2
    } blk_field_e;

    typedef struct packed {
        logic       cap;
        blk_field_e fld;
    } cap_ctl_t;

    typedef struct packed {
        logic start;
        logic word;
        logic finish;
    } ctl_evt_t;

    function automatic logic state_busy(dma_state_e s);
        return s != ST_IDLE;
    endfunction

    function automatic logic state_acking(dma_state_e s);
        return (s == ST_WRITE) || (s == ST_HOLD);
    endfunction

    function automatic blk_field_e next_field(blk_field_e f);
        return blk_field_e'(f + 2'd1);
    endfunction

endpackage

// File: rtl/dma_cb_ctrl.sv
module dma_cb_ctrl
    import dma_cb_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       host_we,
    input  logic       dreq,
    input  logic       mem_gnt,
    input  logic       rd_cnt_zero,
    input  logic       cnt_zero,
    output dma_state_e state,
    output blk_field_e fetch_fld,
    output cap_ctl_t   cap,
    output ctl_evt_t   evt,
    output logic       done,
    output logic       irq
);

    dma_state_e state_q, state_n;
    blk_field_e fld_q, fld_n;
    logic       done_q, irq_q;

    always_comb begin
        state_n = state_q;
        fld_n   = fld_q;
        cap     = '0;
        evt     = '0;
        case (state_q)
            ST_IDLE: begin
                if (host_we) begin
                    evt.start = 1'b1;
                    fld_n     = FLD_SRC;
                    state_n   = ST_FETCH;
                end
            end
            ST_FETCH: begin
                if (mem_gnt) begin
                    cap.cap = 1'b1;
                    cap.fld = fld_q;
                    if (fld_q == FLD_CNT) begin
                        if (rd_cnt_zero) begin
                            evt.finish = 1'b1;
                            state_n    = ST_IDLE;
                        end else begin
                            state_n = ST_WAIT;
                        end
                    end else begin
                        fld_n = next_field(fld_q);
                    end
                end
            end
            ST_WAIT: begin
                if (dreq) state_n = ST_WRITE;
            end
            ST_WRITE: begin
                if (mem_gnt) begin
                    evt.word = 1'b1;
                    state_n  = ST_HOLD;
                end
            end
            ST_HOLD: begin
                if (!dreq) begin
                    if (cnt_zero) begin
                        evt.finish = 1'b1;
                        state_n    = ST_IDLE;
                    end else begin
                        state_n = ST_WAIT;
                    end
                end
            end
            default: state_n = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            fld_q   <= FLD_SRC;
            done_q  <= 1'b0;
            irq_q   <= 1'b0;
        end else begin
            state_q <= state_n;
            fld_q   <= fld_n;
            irq_q   <= evt.finish;
            if (evt.start) begin
                done_q <= 1'b0;
            end else if (evt.finish) begin
                done_q <= 1'b1;
            end
        end
    end

    assign state     = state_q;
    assign fetch_fld = fld_q;
    assign done      = done_q;
    assign irq       = irq_q;

endmodule

// File: rtl/dma_cb_desc.sv
module dma_cb_desc
    import dma_cb_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32,
    parameter int CNT_W  = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  ctl_evt_t          evt,
    input  cap_ctl_t          cap,
    input  blk_field_e        fetch_fld,
    input  logic [ADDR_W-1:0] host_wdata,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic [ADDR_W-1:0] fetch_addr,
    output logic [ADDR_W-1:0] src_ptr,
    output logic [ADDR_W-1:0] dst_ptr,
    output logic              rd_cnt_zero,
    output logic              cnt_zero
);

    localparam int WB    = DATA_W / 8;
    localparam int WB_SH = $clog2(WB);

    logic [ADDR_W-1:0] blk_q, src_q, dst_q;
    logic [CNT_W-1:0]  cnt_q, cnt_n;
    logic [ADDR_W-1:0] rd_ptr;
    logic [CNT_W-1:0]  rd_cnt;

    // Pointer and count fields are cut from the low end of a block word.
    assign rd_ptr = mem_rdata[ADDR_W-1:0];
    assign rd_cnt = mem_rdata[CNT_W-1:0];

    assign fetch_addr  = blk_q + (ADDR_W'(fetch_fld) << WB_SH);
    assign rd_cnt_zero = (rd_cnt == '0);
    assign cnt_zero    = (cnt_q == '0);
    assign cnt_n       = (cnt_q > CNT_W'(WB)) ? (cnt_q - CNT_W'(WB)) : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            blk_q <= '0;
            src_q <= '0;
            dst_q <= '0;
            cnt_q <= '0;
        end else begin
            if (evt.start) blk_q <= host_wdata;
            if (cap.cap) begin
                case (cap.fld)
                    FLD_SRC: src_q <= rd_ptr;
                    FLD_DST: dst_q <= rd_ptr;
                    FLD_CNT: cnt_q <= rd_cnt;
                    default: ;
                endcase
            end
            if (evt.word) begin
                dst_q <= dst_q + ADDR_W'(WB);
                cnt_q <= cnt_n;
            end
        end
    end

    assign src_ptr = src_q;
    assign dst_ptr = dst_q;

endmodule

// File: rtl/dma_cb_port.sv
module dma_cb_port
    import dma_cb_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32
) (
    input  dma_state_e        state,
    input  logic [ADDR_W-1:0] fetch_addr,
    input  logic [ADDR_W-1:0] dst_ptr,
    input  logic [DATA_W-1:0] dev_data,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    output logic              dack
);

    logic writing;

    assign writing   = (state == ST_WRITE);
    assign mem_req   = writing || (state == ST_FETCH);
    assign mem_we    = writing;
    assign mem_addr  = writing ? dst_ptr : fetch_addr;
    assign mem_wdata = writing ? dev_data : '0;
    assign dack      = state_acking(state);

endmodule

// File: rtl/dma_cb_engine.sv
module dma_cb_engine
    import dma_cb_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32,
    parameter int CNT_W  = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              host_we,
    input  logic [ADDR_W-1:0] host_wdata,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic [DATA_W-1:0] mem_rdata,
    input  logic              mem_gnt,
    input  logic              dreq,
    output logic              dack,
    input  logic [DATA_W-1:0] dev_data,
    output logic [ADDR_W-1:0] dev_port,
    output logic              busy,
    output logic              done,
    output logic              irq
);

    dma_state_e        state;
    blk_field_e        fetch_fld;
    cap_ctl_t          cap;
    ctl_evt_t          evt;
    logic              rd_cnt_zero, cnt_zero;
    logic [ADDR_W-1:0] fetch_addr, src_ptr, dst_ptr;

    dma_cb_ctrl u_ctrl (
        .clk         (clk),
        .rst         (rst),
        .host_we     (host_we),
        .dreq        (dreq),
        .mem_gnt     (mem_gnt),
        .rd_cnt_zero (rd_cnt_zero),
        .cnt_zero    (cnt_zero),
        .state       (state),
        .fetch_fld   (fetch_fld),
        .cap         (cap),
        .evt         (evt),
        .done        (done),
        .irq         (irq)
    );

    dma_cb_desc #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W),
        .CNT_W  (CNT_W)
    ) u_desc (
        .clk         (clk),
        .rst         (rst),
        .evt         (evt),
        .cap         (cap),
        .fetch_fld   (fetch_fld),
        .host_wdata  (host_wdata),
        .mem_rdata   (mem_rdata),
        .fetch_addr  (fetch_addr),
        .src_ptr     (src_ptr),
        .dst_ptr     (dst_ptr),
        .rd_cnt_zero (rd_cnt_zero),
        .cnt_zero    (cnt_zero)
    );

    dma_cb_port #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) u_port (
        .state      (state),
        .fetch_addr (fetch_addr),
        .dst_ptr    (dst_ptr),
        .dev_data   (dev_data),
        .mem_req    (mem_req),
        .mem_we     (mem_we),
        .mem_addr   (mem_addr),
        .mem_wdata  (mem_wdata),
        .dack       (dack)
    );

    assign dev_port = src_ptr;
    assign busy     = state_busy(state);

endmodule

// File: rtl/dma_cb_engine_chk.sv
module dma_cb_engine_chk #(
    parameter int ADDR_W = 32
) (
    input logic              clk,
    input logic              rst,
    input logic              host_we,
    input logic              mem_req,
    input logic              mem_we,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              mem_gnt,
    input logic              dreq,
    input logic              dack,
    input logic [ADDR_W-1:0] dev_port,
    input logic              busy,
    input logic              done,
    input logic              irq
);

    assert_start_R2: assert property (@(posedge clk) disable iff (rst)
        (!busy && host_we) |=> (busy && !done));

    assert_fetch_no_ack_R3: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_we) |-> !dack);

    assert_ack_after_req_R4: assert property (@(posedge clk) disable iff (rst)
        $rose(dack) |-> $past(dreq));

    assert_write_under_ack_R4: assert property (@(posedge clk) disable iff (rst)
        (mem_req && mem_we) |-> dack);

    assert_ack_held_R5: assert property (@(posedge clk) disable iff (rst)
        (dack && dreq) |=> dack);

    assert_irq_pulse_R7: assert property (@(posedge clk) disable iff (rst)
        irq |=> !irq);

    assert_irq_done_R7: assert property (@(posedge clk) disable iff (rst)
        irq |-> (done && !busy));

    assert_idle_quiet_R7: assert property (@(posedge clk) disable iff (rst)
        !busy |-> (!dack && !mem_req));

    assert_req_held_R9: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_gnt) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));

    assert_port_steady_R10: assert property (@(posedge clk) disable iff (rst)
        (dack && $past(dack)) |-> $stable(dev_port));

endmodule

bind dma_cb_engine dma_cb_engine_chk #(
    .ADDR_W (ADDR_W)
) u_chk (
    .clk      (clk),
    .rst      (rst),
    .host_we  (host_we),
    .mem_req  (mem_req),
    .mem_we   (mem_we),
    .mem_addr (mem_addr),
    .mem_gnt  (mem_gnt),
    .dreq     (dreq),
    .dack     (dack),
    .dev_port (dev_port),
    .busy     (busy),
    .done     (done),
    .irq      (irq)
);

// File: tb/tb_dma_cb_engine.sv
module tb_dma_cb_engine;

    localparam int AW = 32;
    localparam int DW = 32;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          host_we = 1'b0;
    logic [AW-1:0] host_wdata = '0;
    logic          mem_req, mem_we, mem_gnt;
    logic [AW-1:0] mem_addr;
    logic [DW-1:0] mem_wdata, mem_rdata;
    logic          dreq = 1'b0;
    logic          dack;
    logic [DW-1:0] dev_data = '0;
    logic [AW-1:0] dev_port;
    logic          busy, done, irq;

    logic [31:0]   bmem [64];
    logic          stall = 1'b0;
    logic [1:0]    tick = 2'd0;
    bit            finished = 1'b0;
    int            total = 0;
    int            bad = 0;

    typedef struct {
        logic        we;
        logic [31:0] addr;
        logic [31:0] data;
    } txn_t;
    txn_t exp_q[$];

    always #2ns clk = ~clk;

    always @(posedge clk) tick <= tick + 2'd1;
    assign mem_gnt   = stall ? (tick == 2'd3) : 1'b1;
    assign mem_rdata = bmem[mem_addr[7:2]];

    dma_cb_engine dut (
        .clk        (clk),
        .rst        (rst),
        .host_we    (host_we),
        .host_wdata (host_wdata),
        .mem_req    (mem_req),
        .mem_we     (mem_we),
        .mem_addr   (mem_addr),
        .mem_wdata  (mem_wdata),
        .mem_rdata  (mem_rdata),
        .mem_gnt    (mem_gnt),
        .dreq       (dreq),
        .dack       (dack),
        .dev_data   (dev_data),
        .dev_port   (dev_port),
        .busy       (busy),
        .done       (done),
        .irq        (irq)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] expv);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, expv);
        end
    endtask

    // Scoreboard monitor: every granted bus cycle must match the queue head.
    logic        held = 1'b0;
    logic [31:0] held_addr = '0;
    txn_t        cur;
    always @(negedge clk) begin
        if (!rst) begin
            if (held) chk(mem_req && mem_addr == held_addr, "R9",
                          "request kept until grant", mem_addr, held_addr);
            held      = mem_req && !mem_gnt;
            held_addr = mem_addr;
            if (mem_req && mem_gnt) begin
                if (exp_q.size() == 0) begin
                    chk(1'b0, "R2", "unexpected bus cycle", mem_addr, 32'h0);
                end else begin
                    cur = exp_q.pop_front();
                    chk(mem_we == cur.we && mem_addr == cur.addr, "R3/R6",
                        "bus cycle kind and address", mem_addr, cur.addr);
                    if (cur.we) chk(mem_wdata == cur.data, "R4",
                                    "write data from device", mem_wdata, cur.data);
                    chk(dack == cur.we, "R4", "ack only on data writes",
                        32'(dack), 32'(cur.we));
                end
            end
        end
    end

    task automatic dev_word(input logic [31:0] d, input int hold,
                            input logic [31:0] src, input bit collide);
        int n;
        chk(!dack, "R5", "ack low before new request", 32'(dack), 32'h0);
        dreq     = 1'b1;
        dev_data = d;
        @(negedge clk);
        n = 0;
        while (!dack && n < 60) begin
            @(negedge clk);
            n++;
        end
        chk(dack, "R4", "ack follows request", 32'(dack), 32'h1);
        chk(dev_port == src, "R10", "device pointer shown", dev_port, src);
        for (int h = 0; h < hold; h++) begin
            @(negedge clk);
            chk(dack, "R5", "ack held while request high", 32'(dack), 32'h1);
        end
        dreq = 1'b0;
        if (collide) begin
            host_we    = 1'b1;
            host_wdata = 32'h0000_0080;
        end
        @(negedge clk);
        host_we = 1'b0;
        n = 0;
        while (dack && n < 60) begin
            @(negedge clk);
            n++;
        end
        chk(!dack, "R5", "ack released after request fall", 32'(dack), 32'h0);
    endtask

    task automatic run_job(input logic [31:0] blk, input logic [31:0] src,
                           input logic [31:0] dst, input logic [31:0] cnt,
                           input logic [31:0] base, input bit stall_on,
                           input int hold, input bit disturb, input bit collide);
        int   nw;
        int   n;
        txn_t t;
        stall = stall_on;
        bmem[blk[7:2]]        = src;
        bmem[blk[7:2] + 6'd1] = dst;
        bmem[blk[7:2] + 6'd2] = cnt;
        for (int k = 0; k < 3; k++) begin
            t.we = 1'b0; t.addr = blk + 32'(4 * k); t.data = '0;
            exp_q.push_back(t);
        end
        nw = int'((cnt + 32'd3) >> 2);
        for (int i = 0; i < nw; i++) begin
            t.we = 1'b1; t.addr = dst + 32'(4 * i); t.data = base + 32'(i) * 32'h0101_0101;
            exp_q.push_back(t);
        end
        @(negedge clk);
        host_we    = 1'b1;
        host_wdata = blk;
        @(negedge clk);
        host_we = 1'b0;
        chk(busy && !done, "R2", "start sets busy, clears done", {30'h0, busy, done}, 32'h2);
        if (disturb) begin
            host_we    = 1'b1;
            host_wdata = blk + 32'h40;
            @(negedge clk);
            host_we = 1'b0;
            chk(busy, "R2", "write while busy keeps job", 32'(busy), 32'h1);
        end
        for (int i = 0; i < nw; i++) begin
            dev_word(base + 32'(i) * 32'h0101_0101, hold, src, collide && (i == nw - 1));
        end
        if (nw > 0) begin
            chk(done && irq && !busy, "R7", "completion at last release",
                {29'h0, done, irq, busy}, 32'h6);
            if (collide) chk(!busy && done, "R11", "start at completion ignored",
                             {30'h0, busy, done}, 32'h1);
        end else begin
            n = 0;
            while (!done && n < 60) begin
                @(negedge clk);
                n++;
            end
            chk(done && irq, "R8", "zero count completes after fetch",
                {30'h0, done, irq}, 32'h3);
        end
        @(negedge clk);
        chk(!irq && done, "R7", "irq lasts one cycle", {30'h0, irq, done}, 32'h1);
        dreq = 1'b1;
        for (int k = 0; k < 6; k++) begin
            @(negedge clk);
            chk(!dack && !busy, "R7", "no ack after completion", 32'(dack), 32'h0);
        end
        dreq = 1'b0;
        @(negedge clk);
        chk(exp_q.size() == 0, "R3", "all expected bus cycles seen",
            32'(exp_q.size()), 32'h0);
    endtask

    initial begin
        for (int i = 0; i < 64; i++) bmem[i] = 32'hDEAD_0000 + 32'(i);
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(!busy && !done && !irq && !dack && !mem_req, "R1", "reset state",
            {27'h0, busy, done, irq, dack, mem_req}, 32'h0);
        // R6: four full words, quick device
        run_job(32'h00, 32'h4000_0010, 32'h1000_0000, 32'd16, 32'hA000_0001, 1'b0, 0, 1'b0, 1'b0);
        // R6 rounding with stalled grants and a write while busy (R2, R9)
        run_job(32'h20, 32'h4000_0020, 32'h1000_0100, 32'd10, 32'hB000_0002, 1'b1, 2, 1'b1, 1'b0);
        // R8 zero count
        run_job(32'h40, 32'h4000_0030, 32'h1000_0200, 32'd0, 32'hC000_0003, 1'b0, 1, 1'b0, 1'b0);
        // R11 start lands on completion
        run_job(32'h60, 32'h4000_0040, 32'h1000_0300, 32'd8, 32'hD000_0004, 1'b0, 3, 1'b0, 1'b1);
        // single word, stalled, long hold (R5)
        run_job(32'hA0, 32'h4000_0050, 32'h1000_0400, 32'd4, 32'hE000_0005, 1'b1, 4, 1'b0, 1'b0);
        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog: run did not complete, actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule